// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Decoder

This block recovers characters from one asynchronous serial line that has already been brought into the core clock domain as a plain digital level. The line is resynchronised inside the block and sampled at a fixed rate of 16 oversample ticks per bit period. The tick rate comes from a runtime divider value. A resting line is high. A character begins when the line falls to a low start bit. The start bit is confirmed at its centre, and every later bit is read at its own centre.

Every frame option can be changed at runtime while the line is idle:
- the data width, from 5 to 9 bits;
- whether the first data bit is the least or the most significant bit;
- the parity mode: none, even or odd;
- the stop length: 1, 1.5 or 2 bits;
- whether the line polarity is inverted before decoding;
- an extra marker bit that flags address characters.

Each decoded character is presented on the output for one clock cycle together with its marker bit and two error indications.

Top module: `serial_frame_decoder`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `rx_addr`, `rx_par_err` and `rx_frame_err` are all zero. The result outputs change only in the cycle in which `rx_valid` is high.
- R2: A well-formed frame with 8 data bits, least significant bit first, no parity and 1 stop bit produces exactly one single-cycle `rx_valid` pulse. `rx_data` carries the byte, and both error flags are low.
- R3: `cfg_bits` selects the data width. Values 5 to 9 are used as given, values below 5 act as 5, and values above 9 act as 9. The received bits are right-aligned in `rx_data`, and the unused upper bits are zero.
- R4: When `cfg_msb_first` is 1, the first data bit on the line is the most significant bit of the word. When it is 0, the first data bit is bit 0.
- R5: `cfg_par` selects the parity mode: 0 = none, 1 = even, 2 = odd, and 3 acts as none. Parity covers the data bits and, when present, the marker bit. `rx_par_err` is set when the received parity bit breaks the selected rule. With parity off, `rx_par_err` is always 0.
- R6: `cfg_stop` selects the stop length: 0 = 1 bit, 1 = 1.5 bits (24 ticks), and 2 or 3 = 2 bits. The line is checked at the centre of the first stop bit and at the centre of the last stop slot. A low level at any checked point sets `rx_frame_err` in the same cycle as the `rx_valid` pulse.
- R7: When `cfg_invert` is 1, the line level is complemented before all decoding, so that a low line reads as 1.
- R8: When `cfg_addr_mode` is 1, one extra bit follows the data bits and comes before the parity bit. Its value appears on `rx_addr`. When the mode is off, `rx_addr` is 0.
- R9: A low pulse that has returned high by the centre of the start bit is discarded. It produces no `rx_valid`, and the next proper frame decodes normally.
- R10: An oversample tick occurs every `baud_div` clock cycles, and a value of 0 acts as 1. One bit period therefore lasts 16 × `baud_div` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Serial line level |
| baud_div | input | DIV_W | Clock cycles per oversample tick |
| cfg_bits | input | 4 | Data bit count (5..9) |
| cfg_stop | input | 2 | Stop length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_msb_first | input | 1 | Most significant data bit arrives first |
| cfg_invert | input | 1 | Complement the line before decoding |
| cfg_addr_mode | input | 1 | Expect a marker bit after the data bits |
| rx_data | output | 9 | Decoded word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a finished frame |
| rx_addr | output | 1 | Received marker bit |
| rx_par_err | output | 1 | Parity mismatch in the frame |
| rx_frame_err | output | 1 | Low level seen in a stop slot |

## Verification
A slip in the bit-slot counter or the bit index shows up at the ports when the frame completes. The strobe then carries a shifted word, a misplaced marker bit or a parity flag, or it arrives on the wrong frame or not at all. The failure therefore appears at the end of the first frame that uses the affected option. A start-detection state that does not return to idle after a rejected glitch shows as a missing or spurious strobe on the following frame. The scoreboard compares every field of each strobe and also counts the strobes, so both kinds of fault are reported within one frame time.

// File: rtl/serial_frame_decoder.sv
module serial_frame_decoder #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16,
  parameter int MAXB  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [3:0]       cfg_bits,
  input  logic [1:0]       cfg_stop,
  input  logic [1:0]       cfg_par,
  input  logic             cfg_msb_first,
  input  logic             cfg_invert,
  input  logic             cfg_addr_mode,
  output logic [MAXB-1:0]  rx_data,
  output logic             rx_valid,
  output logic             rx_addr,
  output logic             rx_par_err,
  output logic             rx_frame_err
);
  localparam int CW   = $clog2(2*OVS + 1);
  localparam int IW   = $clog2(MAXB + 1);
  localparam logic [CW-1:0] HALF_END = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] SLOT_END = CW'(OVS - 1);
  localparam logic [CW-1:0] S15_END  = CW'(OVS + (OVS*3)/4 - 1);
  localparam logic [CW-1:0] S2_END   = CW'(2*OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_ADDR, S_PAR, S_STOP} state_t;

  logic [DIV_W-1:0] div_cnt;
  logic [1:0]       sync;
  logic             prev, abit, par_acc, perr, ferr;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [MAXB-1:0]  sh;
  state_t           st;

  wire [DIV_W-1:0] div_lim = (baud_div == '0) ? DIV_W'(1) : baud_div;
  wire             tick    = (div_cnt >= div_lim - DIV_W'(1));
  wire             ln      = sync[1] ^ cfg_invert;
  wire             par_on  = (cfg_par == 2'd1) || (cfg_par == 2'd2);
  wire [IW-1:0]    nbits   = (cfg_bits < 4'd5) ? IW'(5) :
                             (cfg_bits > 4'(MAXB)) ? IW'(MAXB) : IW'(cfg_bits);
  wire [CW-1:0]    stop_end = (cfg_stop == 2'd0) ? SLOT_END :
                              (cfg_stop == 2'd1) ? S15_END : S2_END;
  wire             slot_hit = (cnt == SLOT_END);
  wire             stop_chk = slot_hit || (cnt == stop_end);
  wire state_t     after_data = cfg_addr_mode ? S_ADDR : (par_on ? S_PAR : S_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else div_cnt <= div_cnt + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else sync <= {sync[0], line_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      prev <= 1'b0;
      cnt <= '0;
      idx <= '0;
      sh <= '0;
      abit <= 1'b0;
      par_acc <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      rx_valid <= 1'b0;
      rx_data <= '0;
      rx_addr <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        prev <= ln;
        case (st)
          S_IDLE: if (prev && !ln) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (cnt == HALF_END) begin
            cnt <= '0;
            if (ln) st <= S_IDLE;
            else begin
              st <= S_DATA;
              idx <= '0;
              sh <= '0;
              abit <= 1'b0;
              par_acc <= 1'b0;
              perr <= 1'b0;
              ferr <= 1'b0;
            end
          end else cnt <= cnt + CW'(1);
          S_DATA: if (slot_hit) begin
            cnt <= '0;
            par_acc <= par_acc ^ ln;
            if (cfg_msb_first) sh <= {sh[MAXB-2:0], ln};
            else sh <= sh | (MAXB'(ln) << idx);
            idx <= idx + IW'(1);
            if (idx == nbits - IW'(1)) st <= after_data;
          end else cnt <= cnt + CW'(1);
          S_ADDR: if (slot_hit) begin
            cnt <= '0;
            abit <= ln;
            par_acc <= par_acc ^ ln;
            st <= par_on ? S_PAR : S_STOP;
          end else cnt <= cnt + CW'(1);
          S_PAR: if (slot_hit) begin
            cnt <= '0;
            perr <= par_acc ^ ln ^ (cfg_par == 2'd2);
            st <= S_STOP;
          end else cnt <= cnt + CW'(1);
          S_STOP: begin
            if (stop_chk) ferr <= ferr | !ln;
            if (cnt == stop_end) begin
              st <= S_IDLE;
              cnt <= '0;
              rx_valid <= 1'b1;
              rx_data <= sh;
              rx_addr <= cfg_addr_mode & abit;
              rx_par_err <= perr;
              rx_frame_err <= ferr | !ln;
            end else cnt <= cnt + CW'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module serial_frame_decoder_chk #(
  parameter int MAXB = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      cfg_bits,
  input logic [1:0]      cfg_par,
  input logic            cfg_addr_mode,
  input logic [MAXB-1:0] rx_data,
  input logic            rx_valid,
  input logic            rx_addr,
  input logic            rx_par_err,
  input logic            rx_frame_err
);
  logic [3:0] n_eff;
  always_comb n_eff = (cfg_bits < 4'd5) ? 4'd5 : (cfg_bits > 4'(MAXB)) ? 4'(MAXB) : cfg_bits;

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> n_eff) == '0));
  assert_par_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (cfg_par == 2'd0 || cfg_par == 2'd3)) |-> !rx_par_err);
  assert_addr_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_addr_mode) |-> !rx_addr);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_addr) && $stable(rx_par_err) && $stable(rx_frame_err)));
endmodule

bind serial_frame_decoder serial_frame_decoder_chk #(.MAXB(MAXB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bits(cfg_bits), .cfg_par(cfg_par),
  .cfg_addr_mode(cfg_addr_mode), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_addr(rx_addr), .rx_par_err(rx_par_err), .rx_frame_err(rx_frame_err));

// File: tb/serial_frame_decoder_test.sv
module serial_frame_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_in = 1'b1;
  logic [15:0] baud_div = 16'd2;
  logic [3:0]  cfg_bits = 4'd8;
  logic [1:0]  cfg_stop = 2'd0;
  logic [1:0]  cfg_par = 2'd0;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_invert = 1'b0;
  logic        cfg_addr_mode = 1'b0;
  logic [8:0]  rx_data;
  logic        rx_valid, rx_addr, rx_par_err, rx_frame_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [8:0] d;
    logic a, pe, fe;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  serial_frame_decoder uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .baud_div(baud_div),
    .cfg_bits(cfg_bits), .cfg_stop(cfg_stop), .cfg_par(cfg_par),
    .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
    .cfg_addr_mode(cfg_addr_mode), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_addr(rx_addr), .rx_par_err(rx_par_err), .rx_frame_err(rx_frame_err));

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int eff_div();
    return (baud_div == 0) ? 1 : int'(baud_div);
  endfunction

  task automatic hold(input logic v, input int ticks);
    line_in = v ^ cfg_invert;
    repeat (ticks * eff_div()) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [8:0] d, input logic a, input logic bad_par,
                      input int bad_stop, input string tag);
    int n;
    logic p;
    exp_t e;
    n = (cfg_bits < 5) ? 5 : (cfg_bits > 9) ? 9 : int'(cfg_bits);
    e.d = d & 9'((1 << n) - 1);
    e.a = cfg_addr_mode ? a : 1'b0;
    e.pe = (cfg_par == 2'd1 || cfg_par == 2'd2) ? bad_par : 1'b0;
    e.fe = (bad_stop != 0);
    e.tag = tag;
    q.push_back(e);
    p = 1'b0;
    hold(1'b0, 16);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = cfg_msb_first ? d[n-1-i] : d[i];
      p ^= b;
      hold(b, 16);
    end
    if (cfg_addr_mode) begin
      p ^= a;
      hold(a, 16);
    end
    if (cfg_par == 2'd1 || cfg_par == 2'd2)
      hold(((cfg_par == 2'd2) ? ~p : p) ^ bad_par, 16);
    begin
      int rest;
      rest = (cfg_stop == 2'd0) ? 0 : (cfg_stop == 2'd1) ? 8 : 16;
      hold(bad_stop == 1 ? 1'b0 : 1'b1, 16);
      if (rest > 0) hold(bad_stop == 2 ? 1'b0 : 1'b1, rest);
    end
    hold(1'b1, 32);
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R9 unexpected strobe actual=%h expected=none", rx_data);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " data"}, rx_data, e.d);
        check({e.tag, " addr R8"}, {8'd0, rx_addr}, {8'd0, e.a});
        check({e.tag, " parity R5"}, {8'd0, rx_par_err}, {8'd0, e.pe});
        check({e.tag, " stop R6"}, {8'd0, rx_frame_err}, {8'd0, e.fe});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset valid", {8'd0, rx_valid}, 9'd0);
    check("R1 reset data", rx_data, 9'd0);
    check("R1 reset flags", {6'd0, rx_addr, rx_par_err, rx_frame_err}, 9'd0);
    rst_n = 1'b1;
    hold(1'b1, 40);

    send(9'h0A5, 0, 0, 0, "R2 8N1 a5 R10");
    send(9'h03C, 0, 0, 0, "R2 8N1 3c");
    check("R1 hold after frame", rx_data, 9'h03C);

    cfg_bits = 4'd5;  send(9'h1F3, 0, 0, 0, "R3 five bits");
    cfg_bits = 4'd7;  send(9'h0D5, 0, 0, 0, "R3 seven bits");
    cfg_bits = 4'd9;  send(9'h1A5, 0, 0, 0, "R3 nine bits");
    cfg_bits = 4'd2;  send(9'h0EA, 0, 0, 0, "R3 low clamp");
    cfg_bits = 4'd8;

    cfg_msb_first = 1'b1;
    send(9'h0C1, 0, 0, 0, "R4 msb first");
    cfg_bits = 4'd6; send(9'h02D, 0, 0, 0, "R4 msb six bits");
    cfg_bits = 4'd8; cfg_msb_first = 1'b0;

    cfg_par = 2'd1; send(9'h0B7, 0, 0, 0, "R5 even ok");
    send(9'h0B7, 0, 1, 0, "R5 even bad");
    cfg_par = 2'd2; send(9'h061, 0, 0, 0, "R5 odd ok");
    send(9'h061, 0, 1, 0, "R5 odd bad");
    cfg_par = 2'd0;

    send(9'h055, 0, 0, 1, "R6 one stop low");
    cfg_stop = 2'd1; send(9'h0E2, 0, 0, 0, "R6 1.5 ok");
    send(9'h0E2, 0, 0, 2, "R6 1.5 late low");
    cfg_stop = 2'd2; send(9'h019, 0, 0, 0, "R6 two ok");
    send(9'h019, 0, 0, 1, "R6 two first low");
    send(9'h019, 0, 0, 2, "R6 two second low");
    cfg_stop = 2'd0;

    cfg_invert = 1'b1; line_in = 1'b0;
    hold(1'b1, 40);
    send(9'h05A, 0, 0, 0, "R7 inverted");
    send(9'h0F0, 0, 0, 0, "R7 inverted f0");
    cfg_invert = 1'b0; line_in = 1'b1;
    hold(1'b1, 40);

    cfg_addr_mode = 1'b1; cfg_par = 2'd1;
    send(9'h042, 1, 0, 0, "R8 marker set");
    send(9'h042, 0, 0, 0, "R8 marker clear");
    cfg_addr_mode = 1'b0; cfg_par = 2'd0;
    send(9'h0FF, 1, 0, 0, "R8 mode off");

    hold(1'b0, 3);
    hold(1'b1, 48);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R9 glitch queue actual=%0d expected=0", q.size());
    end
    send(9'h0C3, 0, 0, 0, "R9 after glitch");

    baud_div = 16'd5; hold(1'b1, 8);
    send(9'h096, 0, 0, 0, "R10 div five");
    baud_div = 16'd0; hold(1'b1, 8);
    send(9'h069, 0, 0, 0, "R10 div zero");

    hold(1'b1, 20);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing strobes actual=%0d expected=0", q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule